// File: doc/BRIEF.md
# Bus Grant Chain Node with Passive Release

This block is the grant-chain logic of one interface on a daisy-chained bus. The interface sits on several grant lines at once: a few priority-grant levels and one non-processor (DMA) grant line. Each line enters at `grant_in` and leaves at `grant_out` toward the devices further down the chain. The node answers on exactly one priority level, its own, which is fixed by a parameter. On every other line the grant passes straight through.

When a grant arrives on the node's own level, the node decides once, in the cycle it first sees the grant. If the local interface has a request pending, the node keeps the grant, raises the selection-acknowledge output (`sack`) and flags itself as selected. If optional passive release is enabled and the DMA request line is seen asserted, the node steals the grant instead. It holds it back from the chain and raises `sack`, but never flags itself as selected, so the arbiter can drop the priority grant and move straight to the DMA grant. In every other case the grant is passed down. Each of these choices lasts until the arbiter drops the grant.

The one-cycle pass delay, the number of lines, the node's level and the DMA-grant line index are all parameters. The vector transfer and the data cycle are handled elsewhere.

Top module: `bg_chain_node`

## Requirements
- R1: After reset, every bit of `grant_out`, `sack` and `selected` is 0.
- R2: On the own level (line `OWN_LEVEL`, default 1), with no local request and passive release not applicable, `grant_out[OWN_LEVEL]` rises one clock after `grant_in[OWN_LEVEL]` rises and falls one clock after it falls. `sack` and `selected` stay 0.
- R3: If `own_req` is 1 in the clock where an own-level grant first arrives, then from the next clock until one clock after the grant drops, `sack` and `selected` are 1 and `grant_out[OWN_LEVEL]` is 0.
- R4: If `steal_en` and `npr_seen` are both 1 and `own_req` is 0 in the clock where an own-level grant first arrives, then from the next clock until one clock after the grant drops, `sack` is 1 while `selected` and `grant_out[OWN_LEVEL]` are 0.
- R5: With `steal_en` at 1 but `npr_seen` at 0 when the grant arrives, the grant is passed down as in R2.
- R6: With `npr_seen` at 1 but `steal_en` at 0 when the grant arrives, the grant is passed down as in R2.
- R7: A local request takes precedence over passive release. With `own_req`, `steal_en` and `npr_seen` all at 1, the node behaves as in R3.
- R8: Every line other than the own level, including the DMA-grant line (`NPG_LINE`, default 4), is never stolen or kept. Its `grant_out` bit follows its `grant_in` bit one clock later, whatever the values of `own_req`, `steal_en`, `npr_seen` and the own-level state.
- R9: A request that appears after an own-level grant has already been passed down does not capture that grant. `grant_out[OWN_LEVEL]` stays 1 and `sack` and `selected` stay 0 until the grant drops. The next grant is captured.
- R10: `sack` and `grant_out[OWN_LEVEL]` are never 1 together.
- R11: Once a steal has started, `sack` is held while the grant is held, even if `npr_seen` or `steal_en` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grant_in | input | N_LINES | Grant lines arriving from the arbiter side of the chain |
| npr_seen | input | 1 | Observed DMA request line on the bus |
| own_req | input | 1 | Local interface request on the own level |
| steal_en | input | 1 | Configuration strap enabling passive release |
| grant_out | output | N_LINES | Grant lines passed on down the chain |
| sack | output | 1 | Selection acknowledge to the arbiter |
| selected | output | 1 | Node has taken the own-level grant for its own use |

## Verification
The checker watches several properties on every cycle. `sack` and the own-level `grant_out` are never high together. `selected` never appears without `sack`. `sack` is only ever present one clock after an own-level grant. Each non-own line follows its input one clock later. A passed grant never turns into a capture, and a held steal keeps `sack` while the grant stays. It also checks that the decision taken in a grant's arrival cycle picks the right branch. Only the bench scenarios show that the whole sequence comes out as specified for each input pattern. Those patterns cover the boundaries: a request arriving mid-grant, strap and DMA line disagreeing, request racing against steal, the DMA line dropping mid-steal, and mixed-line grants. Each sequence is checked for its timing, its release and the next grant that follows.

// File: rtl/gnode_pkg.sv
`timescale 1ns/1ps
package gnode_pkg;

   // Own-level handling state, chosen once per grant
   typedef enum logic [1:0] {
      GN_IDLE  = 2'd0,
      GN_PASS  = 2'd1,
      GN_OWN   = 2'd2,
      GN_STEAL = 2'd3
   } gnode_state_e;

   function automatic logic gn_holds_sack(input gnode_state_e s);
      return (s == GN_OWN) || (s == GN_STEAL);
   endfunction

endpackage

// File: rtl/gnode_pass_cell.sv
`timescale 1ns/1ps
module gnode_pass_cell #(
   parameter bit PASS_REG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic g_in,
   input  logic allow_now,
   input  logic allow_nxt,
   output logic g_out
);

   generate
      if (PASS_REG) begin : g_reg
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= g_in & allow_nxt;
         end
         assign g_out = q;
         logic unused_now;
         assign unused_now = allow_now;
      end else begin : g_comb
         assign g_out = g_in & allow_now;
         logic unused_seq;
         assign unused_seq = &{1'b0, clk, rst_n, allow_nxt};
      end
   endgenerate

endmodule

// File: rtl/gnode_arb_fsm.sv
`timescale 1ns/1ps
module gnode_arb_fsm
   import gnode_pkg::*;
#(
   parameter bit STEAL_OK = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          grant,
   input  logic          own_req,
   input  logic          npr_seen,
   input  logic          steal_en,
   output gnode_state_e  state_q,
   output gnode_state_e  state_nxt,
   output logic          sack,
   output logic          selected
);

   gnode_state_e st_q, st_d;
   logic         sack_q, sel_q;
   logic         steal_hit;

   assign steal_hit = STEAL_OK && steal_en && npr_seen;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         GN_IDLE: begin
            if (grant) begin
               if (own_req)        st_d = GN_OWN;
               else if (steal_hit) st_d = GN_STEAL;
               else                st_d = GN_PASS;
            end
         end
         GN_PASS, GN_OWN, GN_STEAL: begin
            if (!grant) st_d = GN_IDLE;
         end
         default: st_d = GN_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= GN_IDLE;
         sack_q <= 1'b0;
         sel_q  <= 1'b0;
      end else begin
         st_q   <= st_d;
         sack_q <= gn_holds_sack(st_d);
         sel_q  <= (st_d == GN_OWN);
      end
   end

   assign state_q   = st_q;
   assign state_nxt = st_d;
   assign sack      = sack_q;
   assign selected  = sel_q;

endmodule

// File: rtl/bg_chain_node.sv
`timescale 1ns/1ps
module bg_chain_node
   import gnode_pkg::*;
#(
   parameter int unsigned N_LINES   = 5,
   parameter int unsigned OWN_LEVEL = 1,
   parameter int unsigned NPG_LINE  = 4,
   parameter bit          PASS_REG  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] grant_in,
   input  logic               npr_seen,
   input  logic               own_req,
   input  logic               steal_en,
   output logic [N_LINES-1:0] grant_out,
   output logic               sack,
   output logic               selected
);

   localparam bit STEAL_OK = (OWN_LEVEL != NPG_LINE);

   generate
      if (N_LINES < 2) begin : g_bad_n
         $error("bg_chain_node: N_LINES must be at least 2");
      end
      if (OWN_LEVEL >= N_LINES) begin : g_bad_own
         $error("bg_chain_node: OWN_LEVEL out of range");
      end
      if (NPG_LINE >= N_LINES) begin : g_bad_npg
         $error("bg_chain_node: NPG_LINE out of range");
      end
   endgenerate

   gnode_state_e own_st_q, own_st_d;

   gnode_arb_fsm #(
      .STEAL_OK (STEAL_OK)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .grant     (grant_in[OWN_LEVEL]),
      .own_req   (own_req),
      .npr_seen  (npr_seen),
      .steal_en  (steal_en),
      .state_q   (own_st_q),
      .state_nxt (own_st_d),
      .sack      (sack),
      .selected  (selected)
   );

   generate
      for (genvar i = 0; i < N_LINES; i++) begin : g_line
         logic al_now, al_nxt;
         if (i == OWN_LEVEL) begin : g_own
            assign al_now = (own_st_q == GN_PASS);
            assign al_nxt = (own_st_d == GN_PASS);
         end else begin : g_thru
            assign al_now = 1'b1;
            assign al_nxt = 1'b1;
         end
         gnode_pass_cell #(
            .PASS_REG (PASS_REG)
         ) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .g_in      (grant_in[i]),
            .allow_now (al_now),
            .allow_nxt (al_nxt),
            .g_out     (grant_out[i])
         );
      end
   endgenerate

endmodule

// File: rtl/gnode_checker.sv
`timescale 1ns/1ps
module gnode_checker #(
   parameter int unsigned N_LINES   = 5,
   parameter int unsigned OWN_LEVEL = 1,
   parameter bit          PASS_REG  = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic [N_LINES-1:0] grant_in,
   input logic               npr_seen,
   input logic               own_req,
   input logic               steal_en,
   input logic [N_LINES-1:0] grant_out,
   input logic               sack,
   input logic               selected
);

   a_r10_sack_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(sack && grant_out[OWN_LEVEL]));

   a_r3_sel_has_sack: assert property (@(posedge clk) disable iff (!rst_n)
      selected |-> sack);

   a_r4_sack_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
      sack |-> $past(grant_in[OWN_LEVEL]));

   a_r9_no_late_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_out[OWN_LEVEL] && grant_in[OWN_LEVEL]) |=> !selected);

   a_r11_steal_held: assert property (@(posedge clk) disable iff (!rst_n)
      (sack && grant_in[OWN_LEVEL]) |=> sack);

   a_r7_own_first: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_in[OWN_LEVEL] && !sack && !grant_out[OWN_LEVEL] && own_req)
      |=> (selected && sack));

   a_r4_steal_start: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_in[OWN_LEVEL] && !sack && !grant_out[OWN_LEVEL] && !own_req
       && steal_en && npr_seen && (OWN_LEVEL != N_LINES - 1))
      |=> (sack && !selected));

   generate
      if (PASS_REG) begin : g_follow
         for (genvar i = 0; i < N_LINES; i++) begin : g_ln
            if (i != OWN_LEVEL) begin : g_chk
               a_r8_line_follow: assert property (@(posedge clk) disable iff (!rst_n)
                  grant_in[i] |=> grant_out[i]);
               a_r8_line_drop: assert property (@(posedge clk) disable iff (!rst_n)
                  !grant_in[i] |=> !grant_out[i]);
            end
         end
      end
   endgenerate

endmodule

bind bg_chain_node gnode_checker #(
   .N_LINES   (N_LINES),
   .OWN_LEVEL (OWN_LEVEL),
   .PASS_REG  (PASS_REG)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .grant_in  (grant_in),
   .npr_seen  (npr_seen),
   .own_req   (own_req),
   .steal_en  (steal_en),
   .grant_out (grant_out),
   .sack      (sack),
   .selected  (selected)
);

// File: tb/bg_chain_node_tb.sv
`timescale 1ns/1ps
module bg_chain_node_tb;

   localparam int unsigned NL = 5;
   localparam logic [NL-1:0] G1  = 5'b00010;  // own level, line 1
   localparam logic [NL-1:0] NPG = 5'b10000;  // DMA grant, line 4

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NL-1:0] grant_in = '0;
   logic          npr_seen = 1'b0, own_req = 1'b0, steal_en = 1'b0;
   logic [NL-1:0] grant_out;
   logic          sack, selected;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   bg_chain_node #(
      .N_LINES (NL), .OWN_LEVEL (1), .NPG_LINE (4), .PASS_REG (1'b1)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .grant_in (grant_in),
      .npr_seen (npr_seen), .own_req (own_req), .steal_en (steal_en),
      .grant_out (grant_out), .sack (sack), .selected (selected)
   );

   typedef struct {
      logic [NL-1:0] g;
      logic          s;
      logic          sel;
      string         tag;
   } exp_t;

   exp_t sb[$];

   // driver: set inputs at negedge, push what must appear after next posedge
   task automatic step(input logic [NL-1:0] gi, input logic rq, input logic np,
                       input logic se, input logic [NL-1:0] eg, input logic es,
                       input logic esel, input string tag);
      exp_t e;
      @(negedge clk);
      grant_in = gi; own_req = rq; npr_seen = np; steal_en = se;
      e.g = eg; e.s = es; e.sel = esel; e.tag = tag;
      sb.push_back(e);
   endtask

   // monitor: pops one expectation per edge while the queue has items
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (grant_out !== e.g || sack !== e.s || selected !== e.sel) begin
               errors++;
               $display("FAIL %s: got gout=%b sack=%b sel=%b, want gout=%b sack=%b sel=%b",
                        e.tag, grant_out, sack, selected, e.g, e.s, e.sel);
            end
         end
      end
   end

   initial begin
      #(5 * 20000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout, want completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      checks++;   // R1 reset state
      if (grant_out !== '0 || sack !== 1'b0 || selected !== 1'b0) begin
         errors++;
         $display("FAIL R1: got gout=%b sack=%b sel=%b, want all zero",
                  grant_out, sack, selected);
      end
      @(negedge clk); rst_n = 1'b1;
      step('0, 0, 0, 0, '0, 0, 0, "R1");

      // R2 plain pass
      step(G1, 0, 0, 0, G1, 0, 0, "R2");
      step(G1, 0, 0, 0, G1, 0, 0, "R2");
      step('0, 0, 0, 0, '0, 0, 0, "R2");

      // R3 own request captures
      step(G1, 1, 0, 0, '0, 1, 1, "R3");
      step(G1, 0, 0, 0, '0, 1, 1, "R3");
      step('0, 0, 0, 0, '0, 0, 0, "R3");

      // R4 steal, then R11 DMA line and strap drop mid-steal
      step(G1, 0, 1, 1, '0, 1, 0, "R4");
      step(G1, 0, 0, 1, '0, 1, 0, "R11");
      step(G1, 0, 0, 0, '0, 1, 0, "R11");
      step('0, 0, 0, 0, '0, 0, 0, "R4");

      // R5 strap on, no DMA request
      step(G1, 0, 0, 1, G1, 0, 0, "R5");
      step('0, 0, 0, 1, '0, 0, 0, "R5");

      // R6 DMA request, strap off
      step(G1, 0, 1, 0, G1, 0, 0, "R6");
      step('0, 0, 1, 0, '0, 0, 0, "R6");

      // R7 request beats steal
      step(G1, 1, 1, 1, '0, 1, 1, "R7");
      step('0, 0, 0, 0, '0, 0, 0, "R7");

      // R8 other lines pass regardless
      step(NPG, 0, 1, 1, NPG, 0, 0, "R8");
      step('0, 0, 1, 1, '0, 0, 0, "R8");
      step(5'b01001, 1, 1, 1, 5'b01001, 0, 0, "R8");
      step('0, 0, 0, 0, '0, 0, 0, "R8");
      step(G1 | NPG, 0, 1, 1, NPG, 1, 0, "R8");
      step('0, 0, 0, 0, '0, 0, 0, "R8");

      // R9 late request does not capture; next grant does
      step(G1, 0, 0, 0, G1, 0, 0, "R9");
      step(G1, 1, 0, 0, G1, 0, 0, "R9");
      step(G1, 1, 1, 1, G1, 0, 0, "R9");
      step('0, 1, 0, 0, '0, 0, 0, "R9");
      step(G1, 1, 0, 0, '0, 1, 1, "R9");
      step('0, 0, 0, 0, '0, 0, 0, "R9");

      // R10 back-to-back grants with one idle clock between
      step(G1, 0, 1, 1, '0, 1, 0, "R10");
      step('0, 0, 0, 0, '0, 0, 0, "R10");
      step(G1, 0, 0, 0, G1, 0, 0, "R10");
      step('0, 0, 0, 0, '0, 0, 0, "R10");

      repeat (3) @(posedge clk);
      #2;
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule